// File: doc/BRIEF.md
# TileLink-UL Register-Driven Burst Master

This block lets a host move 128-bit data words over a TileLink-UL bus by writing a handful of byte-wide registers. The host loads a target address one byte at a time, a beat count minus one, and then a command byte. The engine then performs either a read burst (Get) or a write burst (PutFullData). Every beat is a separate bus transaction: one A-channel request, then its D-channel response.

Write beats are taken from an input word stream. Read beats are delivered on an output word stream. Both streams use valid/ready. A write word is consumed on a clock edge where `wbuf_valid` and `wbuf_ready` are both high, and the engine raises `wbuf_ready` only when it needs the next beat. A read word is held on `rbuf_data`, with `rbuf_valid` high and the data stable, until `rbuf_ready` accepts it. The engine neither drops nor repeats a word, and it does not request the next read beat until the current word has left.

Progress is reported in two status registers, one for reads and one for writes. The status code of a finished burst stays visible until the host writes the null command. Only after that does the engine accept another start command.

Top module: `tl_burst_master`

## Requirements
- R1: After reset, every register reads 0. Both status registers read IDLE (0). `a_valid`, `d_ready`, `wbuf_ready` and `rbuf_valid` are all low.
- R2: The register map is as follows. Offsets 0..3 hold the target address, with the least significant byte at offset 0. Offsets 4 (low) and 5 (high) hold the length. Offset 6 is the command register and reads 0. Offset 7 is the read status and offset 8 is the write status, with codes 0 IDLE, 1 BUSY, 2 DONE, 3 ERROR. Writes to other offsets are ignored, and those offsets read 0.
- R3: A length value L produces exactly L+1 requests. Beat k carries address base + 16·k, taken modulo 2^32.
- R4: Command 0x01 issues Get requests with opcode 4, param 0, size 4, mask 0xFFFF and source 0. It expects D opcode 1 (AccessAckData) on every beat. Each beat's 128-bit data is delivered on the read stream, in order.
- R5: Command 0x02 takes one word from the write stream per beat. It sends that word as a PutFullData (opcode 0) with the same param, size, mask and source as R4, and expects D opcode 0 (AccessAck).
- R6: At most one request is outstanding. No A request is presented until the D response to the previous one has been accepted.
- R7: While a request or read word waits for its ready, its valid stays high and all its fields stay stable.
- R8: During a burst, the active direction's status reads BUSY. After the last response (and, for reads, the last stream hand-off) it reads DONE. The other direction's status stays IDLE.
- R9: The burst ends with status ERROR, and issues no further requests, when either of these happens: `d_error` is high on a response, or a response carries the wrong D opcode for the direction. The data of a failing read beat is not forwarded.
- R10: Start commands are ignored unless the engine is idle. The null command 0x00 returns DONE or ERROR status to IDLE, and is ignored while BUSY. Unknown command codes are ignored.
- R11: Writes to the address or length registers during a burst do not alter the burst in progress.
- R12: The write stream is consumed only during write bursts, one word per beat. A read burst takes no write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte (combinational from reg_addr) |
| wbuf_valid | input | 1 | Write-beat word available |
| wbuf_ready | output | 1 | Engine takes a write-beat word |
| wbuf_data | input | 128 | Write-beat word |
| rbuf_valid | output | 1 | Read-beat word available |
| rbuf_ready | input | 1 | Sink accepts the read-beat word |
| rbuf_data | output | 128 | Read-beat word |
| a_valid | output | 1 | A-channel request valid |
| a_ready | input | 1 | A-channel request accepted |
| a_opcode | output | 3 | A opcode (4 Get, 0 PutFullData) |
| a_param | output | 3 | A param, always 0 |
| a_size | output | 4 | Log2 of beat bytes |
| a_source | output | 4 | Constant source identifier |
| a_address | output | 32 | Beat address |
| a_mask | output | 16 | Byte lane mask, all ones |
| a_data | output | 128 | Write data (0 for Get) |
| d_valid | input | 1 | D-channel response valid |
| d_ready | output | 1 | Engine accepts the response |
| d_opcode | input | 3 | D opcode (0 AccessAck, 1 AccessAckData) |
| d_error | input | 1 | Response error flag |
| d_data | input | 128 | Response data |

## Verification
The bench builds the block with its default parameters: 32-bit address, 128-bit data, 16-bit length and 4-bit source. With these values, bursts of 256 beats run within a few thousand cycles, and a start address just below 2^32 exercises address wrap-around. Because each beat is 16 bytes, the expected a_size is 4 and the expected mask is 0xFFFF. The bench's responder, write source and read sink apply random ready, valid and response delay, so every wait state of the engine is visited under back-pressure.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DONE  = 2'd2,
    ST_ERROR = 2'd3
  } stat_e;

  localparam logic [7:0] CMD_NULL  = 8'h00;
  localparam logic [7:0] CMD_READ  = 8'h01;
  localparam logic [7:0] CMD_WRITE = 8'h02;

  localparam logic [2:0] OPA_PUTFULL = 3'd0;
  localparam logic [2:0] OPA_GET     = 3'd4;
  localparam logic [2:0] OPD_ACK     = 3'd0;
  localparam logic [2:0] OPD_ACKDATA = 3'd1;

endpackage

// File: rtl/tlbm_regs.sv
module tlbm_regs
  import tlbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  stat_e             rd_stat,
  input  stat_e             wr_stat,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [LEN_W-1:0]  cfg_len,
  output logic              go_rd,
  output logic              go_wr,
  output logic              go_clr
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int LEN_BYTES  = LEN_W / 8;
  localparam int OFF_LEN    = ADDR_BYTES;
  localparam int OFF_CMD    = ADDR_BYTES + LEN_BYTES;
  localparam int OFF_RST    = OFF_CMD + 1;
  localparam int OFF_WST    = OFF_CMD + 2;

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              cmd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (reg_addr == REG_AW'(i)) addr_q[8*i +: 8] <= reg_wdata;
      end
      for (int j = 0; j < LEN_BYTES; j++) begin
        if (reg_addr == REG_AW'(OFF_LEN + j)) len_q[8*j +: 8] <= reg_wdata;
      end
    end
  end

  assign cfg_addr = addr_q;
  assign cfg_len  = len_q;

  assign cmd_hit = reg_we && (reg_addr == REG_AW'(OFF_CMD));
  assign go_rd   = cmd_hit && (reg_wdata == CMD_READ);
  assign go_wr   = cmd_hit && (reg_wdata == CMD_WRITE);
  assign go_clr  = cmd_hit && (reg_wdata == CMD_NULL);

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (reg_addr == REG_AW'(i)) reg_rdata = addr_q[8*i +: 8];
    end
    for (int j = 0; j < LEN_BYTES; j++) begin
      if (reg_addr == REG_AW'(OFF_LEN + j)) reg_rdata = len_q[8*j +: 8];
    end
    if (reg_addr == REG_AW'(OFF_RST)) reg_rdata = {6'b0, rd_stat};
    if (reg_addr == REG_AW'(OFF_WST)) reg_rdata = {6'b0, wr_stat};
  end

endmodule

// File: rtl/tlbm_stepper.sv
module tlbm_stepper #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int STEP   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);

  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= load_addr;
      rem_q  <= load_len;
    end else if (adv) begin
      addr_q <= addr_q + ADDR_W'(STEP);
      rem_q  <= rem_q - LEN_W'(1);
    end
  end

  assign cur_addr = addr_q;
  assign last     = (rem_q == '0);

endmodule

// File: rtl/tlbm_engine.sv
module tlbm_engine
  import tlbm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 128,
  parameter int LEN_W     = 16,
  parameter int SRC_W     = 4,
  parameter int SOURCE_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_rd,
  input  logic                go_wr,
  input  logic                go_clr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                wbuf_valid,
  output logic                wbuf_ready,
  input  logic [DATA_W-1:0]   wbuf_data,
  output logic                rbuf_valid,
  input  logic                rbuf_ready,
  output logic [DATA_W-1:0]   rbuf_data,
  output logic                a_valid,
  input  logic                a_ready,
  output logic [2:0]          a_opcode,
  output logic [2:0]          a_param,
  output logic [3:0]          a_size,
  output logic [SRC_W-1:0]    a_source,
  output logic [ADDR_W-1:0]   a_address,
  output logic [DATA_W/8-1:0] a_mask,
  output logic [DATA_W-1:0]   a_data,
  input  logic                d_valid,
  output logic                d_ready,
  input  logic [2:0]          d_opcode,
  input  logic                d_error,
  input  logic [DATA_W-1:0]   d_data,
  output stat_e               rd_stat,
  output stat_e               wr_stat
);

  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int SIZE_LOG   = $clog2(BEAT_BYTES);

  typedef enum logic [2:0] {
    E_IDLE, E_FETCH, E_REQ, E_RESP, E_PUSH, E_END
  } eng_e;

  eng_e              st_q, st_d;
  logic              is_rd_q, is_rd_d;
  logic              fail_q, fail_d;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              ld, adv, last;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        d_want;
  logic              d_bad;
  stat_e             stat;

  tlbm_stepper #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .STEP   (BEAT_BYTES)
  ) u_stepper (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .adv       (adv),
    .load_addr (cfg_addr),
    .load_len  (cfg_len),
    .cur_addr  (cur_addr),
    .last      (last)
  );

  assign d_want = is_rd_q ? OPD_ACKDATA : OPD_ACK;
  assign d_bad  = d_error || (d_opcode != d_want);

  always_comb begin
    st_d    = st_q;
    is_rd_d = is_rd_q;
    fail_d  = fail_q;
    ld      = 1'b0;
    adv     = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (go_rd) begin
          is_rd_d = 1'b1;
          ld      = 1'b1;
          st_d    = E_REQ;
        end else if (go_wr) begin
          is_rd_d = 1'b0;
          ld      = 1'b1;
          st_d    = E_FETCH;
        end
      end
      E_FETCH: if (wbuf_valid) st_d = E_REQ;
      E_REQ:   if (a_ready) st_d = E_RESP;
      E_RESP: begin
        if (d_valid) begin
          if (d_bad) begin
            fail_d = 1'b1;
            st_d   = E_END;
          end else if (is_rd_q) begin
            st_d = E_PUSH;
          end else if (last) begin
            st_d = E_END;
          end else begin
            adv  = 1'b1;
            st_d = E_FETCH;
          end
        end
      end
      E_PUSH: begin
        if (rbuf_ready) begin
          if (last) begin
            st_d = E_END;
          end else begin
            adv  = 1'b1;
            st_d = E_REQ;
          end
        end
      end
      E_END: begin
        if (go_clr) begin
          fail_d = 1'b0;
          st_d   = E_IDLE;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= E_IDLE;
      is_rd_q <= 1'b0;
      fail_q  <= 1'b0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else begin
      st_q    <= st_d;
      is_rd_q <= is_rd_d;
      fail_q  <= fail_d;
      if (st_q == E_FETCH && wbuf_valid) wdat_q <= wbuf_data;
      if (st_q == E_RESP && d_valid) rdat_q <= d_data;
    end
  end

  assign wbuf_ready = (st_q == E_FETCH);
  assign a_valid    = (st_q == E_REQ);
  assign d_ready    = (st_q == E_RESP);
  assign rbuf_valid = (st_q == E_PUSH);
  assign rbuf_data  = rdat_q;

  assign a_opcode  = is_rd_q ? OPA_GET : OPA_PUTFULL;
  assign a_param   = 3'd0;
  assign a_size    = 4'(SIZE_LOG);
  assign a_source  = SRC_W'(SOURCE_ID);
  assign a_address = cur_addr;
  assign a_mask    = '1;
  assign a_data    = is_rd_q ? '0 : wdat_q;

  always_comb begin
    case (st_q)
      E_IDLE:  stat = ST_IDLE;
      E_END:   stat = fail_q ? ST_ERROR : ST_DONE;
      default: stat = ST_BUSY;
    endcase
  end

  assign rd_stat = is_rd_q ? stat : ST_IDLE;
  assign wr_stat = is_rd_q ? ST_IDLE : stat;

endmodule

// File: rtl/tl_burst_master.sv
module tl_burst_master
  import tlbm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 128,
  parameter int LEN_W     = 16,
  parameter int SRC_W     = 4,
  parameter int SOURCE_ID = 0,
  parameter int REG_AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                wbuf_valid,
  output logic                wbuf_ready,
  input  logic [DATA_W-1:0]   wbuf_data,
  output logic                rbuf_valid,
  input  logic                rbuf_ready,
  output logic [DATA_W-1:0]   rbuf_data,
  output logic                a_valid,
  input  logic                a_ready,
  output logic [2:0]          a_opcode,
  output logic [2:0]          a_param,
  output logic [3:0]          a_size,
  output logic [SRC_W-1:0]    a_source,
  output logic [ADDR_W-1:0]   a_address,
  output logic [DATA_W/8-1:0] a_mask,
  output logic [DATA_W-1:0]   a_data,
  input  logic                d_valid,
  output logic                d_ready,
  input  logic [2:0]          d_opcode,
  input  logic                d_error,
  input  logic [DATA_W-1:0]   d_data
);

  stat_e             rd_stat_w, wr_stat_w;
  logic [ADDR_W-1:0] cfg_addr;
  logic [LEN_W-1:0]  cfg_len;
  logic              go_rd, go_wr, go_clr;

  tlbm_regs #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .REG_AW (REG_AW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rd_stat   (rd_stat_w),
    .wr_stat   (wr_stat_w),
    .cfg_addr  (cfg_addr),
    .cfg_len   (cfg_len),
    .go_rd     (go_rd),
    .go_wr     (go_wr),
    .go_clr    (go_clr)
  );

  tlbm_engine #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LEN_W     (LEN_W),
    .SRC_W     (SRC_W),
    .SOURCE_ID (SOURCE_ID)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_rd      (go_rd),
    .go_wr      (go_wr),
    .go_clr     (go_clr),
    .cfg_addr   (cfg_addr),
    .cfg_len    (cfg_len),
    .wbuf_valid (wbuf_valid),
    .wbuf_ready (wbuf_ready),
    .wbuf_data  (wbuf_data),
    .rbuf_valid (rbuf_valid),
    .rbuf_ready (rbuf_ready),
    .rbuf_data  (rbuf_data),
    .a_valid    (a_valid),
    .a_ready    (a_ready),
    .a_opcode   (a_opcode),
    .a_param    (a_param),
    .a_size     (a_size),
    .a_source   (a_source),
    .a_address  (a_address),
    .a_mask     (a_mask),
    .a_data     (a_data),
    .d_valid    (d_valid),
    .d_ready    (d_ready),
    .d_opcode   (d_opcode),
    .d_error    (d_error),
    .d_data     (d_data),
    .rd_stat    (rd_stat_w),
    .wr_stat    (wr_stat_w)
  );

endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input logic                clk,
  input logic                rst_n,
  input logic                a_valid,
  input logic                a_ready,
  input logic [2:0]          a_opcode,
  input logic [3:0]          a_size,
  input logic [ADDR_W-1:0]   a_address,
  input logic [DATA_W/8-1:0] a_mask,
  input logic [DATA_W-1:0]   a_data,
  input logic                d_valid,
  input logic                d_ready,
  input logic                rbuf_valid,
  input logic                rbuf_ready,
  input logic [DATA_W-1:0]   rbuf_data,
  input logic                wbuf_ready,
  input logic [1:0]          rd_stat,
  input logic [1:0]          wr_stat
);

  localparam int SIZE_LOG = $clog2(DATA_W / 8);

  logic outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (a_valid && a_ready) outst <= 1'b1;
    else if (d_valid && d_ready) outst <= 1'b0;
  end

  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> !outst);

  p_a_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !a_ready |=> a_valid && $stable(a_address) && $stable(a_opcode) && $stable(a_data));

  p_rbuf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rbuf_valid && !rbuf_ready |=> rbuf_valid && $stable(rbuf_data));

  p_opcode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (a_opcode == 3'd4 || a_opcode == 3'd0));

  p_full_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (a_size == 4'(SIZE_LOG) && (&a_mask)));

  p_status_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((rd_stat != 2'd0) && (wr_stat != 2'd0)));

  p_wbuf_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_ready |-> (!a_valid && !d_ready && !outst));

endmodule

bind tl_burst_master tlbm_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_valid    (a_valid),
  .a_ready    (a_ready),
  .a_opcode   (a_opcode),
  .a_size     (a_size),
  .a_address  (a_address),
  .a_mask     (a_mask),
  .a_data     (a_data),
  .d_valid    (d_valid),
  .d_ready    (d_ready),
  .rbuf_valid (rbuf_valid),
  .rbuf_ready (rbuf_ready),
  .rbuf_data  (rbuf_data),
  .wbuf_ready (wbuf_ready),
  .rd_stat    (rd_stat_w),
  .wr_stat    (wr_stat_w)
);

// File: tb/test_tl_burst_master.sv
module test_tl_burst_master;

  localparam logic [3:0] OFF_CMD = 4'd6;
  localparam logic [3:0] OFF_RST = 4'd7;
  localparam logic [3:0] OFF_WST = 4'd8;
  localparam int LOGN = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         reg_we = 0;
  logic [3:0]   reg_addr = 0;
  logic [7:0]   reg_wdata = 0;
  logic [7:0]   reg_rdata;
  logic         wbuf_valid = 0, wbuf_ready;
  logic [127:0] wbuf_data = 0;
  logic         rbuf_valid, rbuf_ready = 0;
  logic [127:0] rbuf_data;
  logic         a_valid, a_ready = 0;
  logic [2:0]   a_opcode, a_param;
  logic [3:0]   a_size, a_source;
  logic [31:0]  a_address;
  logic [15:0]  a_mask;
  logic [127:0] a_data;
  logic         d_valid = 0, d_ready, d_error = 0;
  logic [2:0]   d_opcode = 0;
  logic [127:0] d_data = 0;

  tl_burst_master i_tl_burst_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wbuf_valid(wbuf_valid), .wbuf_ready(wbuf_ready), .wbuf_data(wbuf_data),
    .rbuf_valid(rbuf_valid), .rbuf_ready(rbuf_ready), .rbuf_data(rbuf_data),
    .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode), .a_param(a_param),
    .a_size(a_size), .a_source(a_source), .a_address(a_address), .a_mask(a_mask),
    .a_data(a_data), .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
    .d_error(d_error), .d_data(d_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] rd_word(input logic [31:0] a);
    return {a ^ 32'hC3A5_5A3C, ~a, a + 32'h1357_9BDF, a};
  endfunction

  function automatic logic [127:0] wr_word(input logic [31:0] tag, input int i);
    logic [31:0] iv;
    iv = 32'(i);
    return {tag, iv ^ 32'h0F0F_0F0F, tag ^ (iv << 8), iv * 32'h9E37_79B9};
  endfunction

  // burst context
  bit          cur_rd;
  int          err_beat, bad_beat, pct, exp_len;
  logic [31:0] exp_base, wtag;
  // monitor state
  logic [31:0]  a_addr_log [LOGN];
  logic [2:0]   a_op_log   [LOGN];
  logic [127:0] a_dat_log  [LOGN];
  logic [127:0] r_log      [LOGN];
  bit           a_field_bad;
  int a_cnt, r_cnt, w_ptr, d_beat, proto_err, dly;
  bit pend, a_fire, d_fire, w_fire, r_fire;
  logic [31:0]  pend_addr;
  logic [127:0] r_cap;

  always @(negedge clk) begin
    if (!rst_n) begin
      a_ready = 0; d_valid = 0; wbuf_valid = 0; rbuf_ready = 0;
      pend = 0; a_fire = 0; d_fire = 0; w_fire = 0; r_fire = 0;
    end else begin
      if (d_fire) begin d_valid = 0; pend = 0; d_beat++; end
      if (a_fire) begin pend = 1; dly = int'($urandom % 4); end
      if (w_fire) w_ptr++;
      if (r_fire) begin
        if (r_cnt < LOGN) r_log[r_cnt] = r_cap;
        r_cnt++;
      end
      a_ready = ($urandom % 100) < pct;
      if (pend && !d_valid) begin
        if (dly == 0) begin
          d_valid  = 1;
          d_error  = (d_beat == err_beat);
          d_opcode = cur_rd ? 3'd1 : 3'd0;
          if (d_beat == bad_beat) d_opcode = cur_rd ? 3'd0 : 3'd1;
          d_data   = cur_rd ? rd_word(pend_addr) : {$urandom, $urandom, $urandom, $urandom};
        end else dly--;
      end
      wbuf_valid = ($urandom % 100) < pct;
      wbuf_data  = wr_word(wtag, w_ptr);
      rbuf_ready = ($urandom % 100) < pct;
      a_fire = a_valid && a_ready;
      if (a_fire) begin
        if (pend) proto_err++;
        if (a_cnt < LOGN) begin
          a_addr_log[a_cnt] = a_address;
          a_op_log[a_cnt]   = a_opcode;
          a_dat_log[a_cnt]  = a_data;
        end
        if (a_size != 4'd4 || a_mask != 16'hFFFF || a_param != 3'd0 || a_source != 4'd0)
          a_field_bad = 1;
        pend_addr = a_address;
        a_cnt++;
      end
      d_fire = d_valid && d_ready;
      w_fire = wbuf_valid && wbuf_ready;
      r_fire = rbuf_valid && rbuf_ready;
      if (r_fire) r_cap = rbuf_data;
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clear_logs();
    a_cnt = 0; r_cnt = 0; w_ptr = 0; d_beat = 0; proto_err = 0; a_field_bad = 0;
  endtask

  task automatic start_burst(input bit rd, input logic [31:0] base, input int len,
                             input int eb, input int bb, input int p);
    cur_rd = rd; err_beat = eb; bad_beat = bb; pct = p;
    exp_base = base; exp_len = len; wtag = $urandom;
    clear_logs();
    for (int j = 0; j < 4; j++) reg_write(4'(j), base[8*j +: 8]);
    reg_write(4'd4, len[7:0]);
    reg_write(4'd5, len[15:8]);
    reg_write(OFF_CMD, rd ? 8'h01 : 8'h02);
  endtask

  task automatic finish_burst(input bit do_clear, input string tag);
    logic [7:0] st, other;
    int stop, nexp, npush, bad;
    logic [31:0] ea;
    for (int n = 0; n < 30000; n++) begin
      reg_read(cur_rd ? OFF_RST : OFF_WST, st);
      if (st != 8'd1) break;
    end
    repeat (4) @(negedge clk);
    stop = -1;
    if (err_beat >= 0 && err_beat <= exp_len) stop = err_beat;
    if (bad_beat >= 0 && bad_beat <= exp_len && (stop < 0 || bad_beat < stop)) stop = bad_beat;
    nexp  = (stop >= 0) ? stop + 1 : exp_len + 1;
    npush = (stop >= 0) ? stop : exp_len + 1;
    // R3 / R9: request count
    chk(a_cnt == nexp, "R3", {tag, " request count"}, 128'(a_cnt), 128'(nexp));
    bad = -1;
    for (int i = 0; i < nexp && i < LOGN; i++)
      if (bad < 0 && a_addr_log[i] != exp_base + 32'(16 * i)) bad = i;
    ea = (bad >= 0) ? exp_base + 32'(16 * bad) : 32'h0;
    chk(bad < 0, "R3", {tag, " beat address"}, (bad >= 0) ? 128'(a_addr_log[bad]) : 128'h0, 128'(ea));
    bad = -1;
    for (int i = 0; i < nexp && i < LOGN; i++)
      if (bad < 0 && a_op_log[i] != (cur_rd ? 3'd4 : 3'd0)) bad = i;
    chk(bad < 0 && !a_field_bad, cur_rd ? "R4" : "R5", {tag, " opcode/size/mask/param/source"},
        (bad >= 0) ? 128'(a_op_log[bad]) : 128'(a_field_bad), cur_rd ? 128'd4 : 128'd0);
    chk(proto_err == 0, "R6", {tag, " request while response pending"}, 128'(proto_err), 128'd0);
    if (cur_rd) begin
      chk(r_cnt == npush, "R9", {tag, " read words forwarded"}, 128'(r_cnt), 128'(npush));
      bad = -1;
      for (int i = 0; i < npush && i < LOGN; i++)
        if (bad < 0 && r_log[i] != rd_word(exp_base + 32'(16 * i))) bad = i;
      chk(bad < 0, "R4", {tag, " read stream data"}, (bad >= 0) ? r_log[bad] : 128'h0,
          (bad >= 0) ? rd_word(exp_base + 32'(16 * bad)) : 128'h0);
      chk(w_ptr == 0, "R12", {tag, " write words taken by read burst"}, 128'(w_ptr), 128'd0);
    end else begin
      chk(w_ptr == nexp, "R12", {tag, " write words taken"}, 128'(w_ptr), 128'(nexp));
      bad = -1;
      for (int i = 0; i < nexp && i < LOGN; i++)
        if (bad < 0 && a_dat_log[i] != wr_word(wtag, i)) bad = i;
      chk(bad < 0, "R5", {tag, " put data"}, (bad >= 0) ? a_dat_log[bad] : 128'h0,
          (bad >= 0) ? wr_word(wtag, bad) : 128'h0);
    end
    reg_read(cur_rd ? OFF_RST : OFF_WST, st);
    reg_read(cur_rd ? OFF_WST : OFF_RST, other);
    chk(st == ((stop >= 0) ? 8'd3 : 8'd2), (stop >= 0) ? "R9" : "R8", {tag, " final status"},
        128'(st), (stop >= 0) ? 128'd3 : 128'd2);
    chk(other == 8'd0, "R8", {tag, " other-direction status"}, 128'(other), 128'd0);
    if (do_clear) begin
      reg_write(OFF_CMD, 8'h00);
      reg_read(OFF_RST, st);
      reg_read(OFF_WST, other);
      chk(st == 0 && other == 0, "R10", {tag, " null clears status"}, 128'({st, other}), 128'd0);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    int dummy;
    dummy = int'($urandom(32'd20240611));
    err_beat = -1; bad_beat = -1; pct = 100; wtag = 0; cur_rd = 0;
    clear_logs();
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(!a_valid && !d_ready && !wbuf_ready && !rbuf_valid, "R1", "handshake outputs after reset",
        128'({a_valid, d_ready, wbuf_ready, rbuf_valid}), 128'd0);
    for (int o = 0; o <= 8; o++) begin
      reg_read(4'(o), v);
      chk(v == 8'd0, "R1", $sformatf("register %0d after reset", o), 128'(v), 128'd0);
    end

    // R2: byte order and register map
    reg_write(4'd0, 8'h78); reg_write(4'd1, 8'h56);
    reg_write(4'd2, 8'h34); reg_write(4'd3, 8'h12);
    reg_write(4'd4, 8'hAB); reg_write(4'd5, 8'hCD);
    reg_write(4'd12, 8'hFF);
    begin
      logic [31:0] ra;
      for (int j = 0; j < 4; j++) begin reg_read(4'(j), v); ra[8*j +: 8] = v; end
      chk(ra == 32'h1234_5678, "R2", "address bytes little-endian", 128'(ra), 128'h1234_5678);
    end
    reg_read(4'd4, v); reg_read(4'd5, v2);
    chk({v2, v} == 16'hCDAB, "R2", "length readback", 128'({v2, v}), 128'hCDAB);
    reg_read(4'd12, v);
    chk(v == 0, "R2", "unmapped offset", 128'(v), 128'd0);
    reg_read(OFF_CMD, v);
    chk(v == 0, "R2", "command reads zero", 128'(v), 128'd0);
    reg_write(OFF_CMD, 8'h7E);
    repeat (10) @(negedge clk);
    chk(a_cnt == 0 && !a_valid, "R10", "unknown command ignored", 128'(a_cnt), 128'd0);

    // directed bursts
    start_burst(1, 32'h4000_1000, 0, -1, -1, 100); finish_burst(1, "read single");
    start_burst(0, 32'h4000_2000, 0, -1, -1, 100); finish_burst(1, "write single");
    start_burst(1, 32'h4000_1000, 3, -1, -1, 50);  finish_burst(1, "read 4 beats");
    start_burst(0, 32'h4000_2000, 3, -1, -1, 40);  finish_burst(1, "write 4 beats");
    start_burst(1, 32'hFFFF_FFE0, 3, -1, -1, 70);  finish_burst(1, "read address wrap");
    start_burst(0, 32'h2000_0000, 255, -1, -1, 80); finish_burst(1, "write 256 beats");
    start_burst(1, 32'h2000_0000, 255, -1, -1, 80); finish_burst(1, "read 256 beats");
    start_burst(1, 32'h3000_0000, 5, 2, -1, 60);   finish_burst(1, "read d_error beat 2");
    start_burst(0, 32'h3000_1000, 4, 0, -1, 60);   finish_burst(1, "write d_error beat 0");
    start_burst(0, 32'h3000_2000, 3, -1, 1, 60);   finish_burst(1, "write bad opcode");
    start_burst(1, 32'h3000_3000, 3, -1, 3, 60);   finish_burst(1, "read bad opcode last");

    // R10: start while DONE ignored
    start_burst(1, 32'h5000_0000, 1, -1, -1, 100); finish_burst(0, "read kept done");
    clear_logs();
    reg_write(OFF_CMD, 8'h02);
    repeat (30) @(negedge clk);
    chk(a_cnt == 0 && w_ptr == 0, "R10", "start while DONE ignored", 128'(a_cnt), 128'd0);
    reg_read(OFF_RST, v); reg_read(OFF_WST, v2);
    chk(v == 2 && v2 == 0, "R10", "status kept after ignored start", 128'({v, v2}), 128'h0200);
    reg_write(OFF_CMD, 8'h00);
    reg_read(OFF_RST, v);
    chk(v == 0, "R10", "null clears DONE", 128'(v), 128'd0);

    // R11 and R10: config writes and null during a busy burst
    start_burst(1, 32'h6000_0000, 40, -1, -1, 30);
    repeat (15) @(negedge clk);
    reg_write(4'd0, 8'hEE);
    reg_write(4'd4, 8'h00);
    reg_write(4'd5, 8'h00);
    reg_write(OFF_CMD, 8'h00);
    reg_read(OFF_RST, v);
    chk(v == 1, "R10", "null ignored while BUSY", 128'(v), 128'd1);
    finish_burst(1, "R11 config writes mid-burst");

    // constrained random bursts
    for (int k = 0; k < 8; k++) begin
      bit rd;
      int len, eb, p;
      logic [31:0] base;
      rd   = $urandom % 2;
      len  = int'($urandom % 24);
      base = {$urandom, 4'h0} >> 4 << 4;
      eb   = (($urandom % 4) == 0) ? int'($urandom % (len + 1)) : -1;
      p    = 20 + int'($urandom % 81);
      start_burst(rd, base, len, eb, -1, p);
      finish_burst(1, $sformatf("random burst %0d", k));
    end

    summary();
    $finish;
  end

endmodule